// File: doc/BRIEF.md
# Checkpoint and Rollback Controller

This controller keeps a recovery point for a processor whose last-level cache is exposed to sudden tampering. During normal execution it counts run cycles. When the programmed interval elapses, it halts the CPU and takes a checkpoint in three steps: it saves the architectural state to non-volatile storage, it requests a write-back of dirty lines at every cache level, and it opens the gate that lets the cache write buffer drain to memory. Outside a checkpoint that gate stays closed. Memory therefore never sees a write that a later rollback would have to undo.

A sudden attack is reported as a level on `attack_i`. On it, the controller does four things: it discards the buffered writes, pulses a pipeline flush, requests a restore of the last saved state and raises cache bypass. No checkpoint is taken while the attack lasts. When the attack ends, bypass drops, the last-level cache is invalidated and periodic checkpointing resumes. From then on the interval is the shorter of the two programmed values. A full write buffer forces an immediate checkpoint.

Top module: `ckpt_ctrl`

## Requirements
- R1: While `rst_ni` is low, every request, strobe, gate, halt and bypass output is 0.
- R2: Before any attack, `save_req_o` rises after exactly `INTVL_LONG` run cycles. A run cycle is one in which both `cpu_halt_o` and `bypass_o` are low. The count starts at reset release or at the end of the previous checkpoint.
- R3: `save_req_o` stays high until `save_ack_i` is seen. `wb_req_o` rises in the cycle after that acknowledge and stays high until `wb_ack_i`. The two requests never overlap.
- R4: `wbuf_drain_o` rises in the cycle after the write-back acknowledge. It stays high until the buffer occupancy is zero and is low at every other time. Occupancy increments on `wbuf_wr_i` and decrements on `wbuf_rd_i` only while the gate is open.
- R5: When occupancy reaches `WBUF_DEPTH` during a run cycle, a checkpoint starts in the next cycle, with `cpu_halt_o` and `save_req_o` high.
- R6: `cpu_halt_o` is high whenever a save, write-back, drain, restore or invalidate is in progress. It is low in run cycles and in steady bypass.
- R7: If `attack_i` is high in a run cycle, the next cycle has `restore_req_o`, `flush_o`, `wbuf_clear_o`, `bypass_o` and `cpu_halt_o` all high. `flush_o` lasts one cycle. Occupancy is reset to zero, so writes that were pending do not count toward the full limit.
- R8: No checkpoint is started while `bypass_o` is high.
- R9: When `attack_i` falls during bypass, the next cycle has `bypass_o` low and `llc_inval_req_o` high. The request holds until `llc_inval_ack_i`, and normal running follows.
- R10: After the first attack, the periodic interval becomes `INTVL_SHORT` run cycles until reset.
- R11: The interval count restarts from zero after a forced checkpoint, the same as after a periodic one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| attack_i | input | 1 | Sudden-attack indication, level |
| wbuf_wr_i | input | 1 | Entry accepted into the write buffer |
| wbuf_rd_i | input | 1 | Entry committed from the buffer to memory |
| save_req_o | output | 1 | Save registers and PC to non-volatile storage |
| save_ack_i | input | 1 | Save complete |
| wb_req_o | output | 1 | Write back dirty data at all cache levels |
| wb_ack_i | input | 1 | Write-back complete |
| restore_req_o | output | 1 | Reload the last saved state |
| restore_ack_i | input | 1 | Restore complete |
| flush_o | output | 1 | One-cycle pipeline flush strobe |
| wbuf_clear_o | output | 1 | One-cycle discard of buffered entries |
| wbuf_drain_o | output | 1 | Gate allowing the buffer to commit to memory |
| cpu_halt_o | output | 1 | Holds the CPU |
| bypass_o | output | 1 | Routes traffic around the last-level cache |
| llc_inval_req_o | output | 1 | Invalidate the last-level cache |
| llc_inval_ack_i | input | 1 | Invalidate complete |

## Verification
The bench builds the block with `INTVL_LONG` = 40, `INTVL_SHORT` = 12 and `WBUF_DEPTH` = 8. With these values several periodic checkpoints, a forced one, an attack held for three long intervals and the shortened intervals after it all fit in a few hundred cycles. The small depth lets eight pushes fill the buffer well inside one interval, so forcing can be told apart from expiry. The short interval stays longer than the three pushes made just after recovery, so the discarded occupancy shows up as a missing forced checkpoint rather than being hidden by a periodic one.

// File: rtl/ckpt_pkg.sv
package ckpt_pkg;
  typedef enum logic [2:0] {
    ST_RUN,
    ST_SAVE,
    ST_WB,
    ST_DRAIN,
    ST_REST,
    ST_BYP,
    ST_INVAL
  } ckpt_st_e;
endpackage

// File: rtl/ckpt_occ.sv
module ckpt_occ #(
  parameter int WBUF_DEPTH = 8,
  localparam int OCC_W = $clog2(WBUF_DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic             gate_i,
  input  logic             clear_i,
  output logic             full_o,
  output logic             empty_o,
  output logic [OCC_W-1:0] occ_o
);
  localparam logic [OCC_W-1:0] OCC_MAX = OCC_W'(WBUF_DEPTH);

  logic [OCC_W-1:0] occ_q;
  logic             inc, dec;

  assign inc = wr_i && (occ_q != OCC_MAX);
  // commits only count while the drain gate is open
  assign dec = rd_i && gate_i && (occ_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      occ_q <= '0;
    end else if (clear_i) begin
      occ_q <= '0;
    end else begin
      case ({inc, dec})
        2'b10:   occ_q <= occ_q + 1'b1;
        2'b01:   occ_q <= occ_q - 1'b1;
        default: occ_q <= occ_q;
      endcase
    end
  end

  assign full_o  = (occ_q == OCC_MAX);
  assign empty_o = (occ_q == '0);
  assign occ_o   = occ_q;
endmodule

// File: rtl/ckpt_intvl.sv
module ckpt_intvl #(
  parameter int INTVL_LONG  = 1000,
  parameter int INTVL_SHORT = 250,
  localparam int CNT_W = $clog2(INTVL_LONG + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic mark_i,
  output logic hit_o
);
  localparam logic [CNT_W-1:0] LIM_L = CNT_W'(INTVL_LONG - 1);
  localparam logic [CNT_W-1:0] LIM_S = CNT_W'(INTVL_SHORT - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;
  logic             seen_q;

  assign lim   = seen_q ? LIM_S : LIM_L;
  assign hit_o = run_i && (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      if (mark_i) seen_q <= 1'b1;
      // any non-run cycle restarts the interval
      if (!run_i)      cnt_q <= '0;
      else if (!hit_o) cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/ckpt_seq.sv
module ckpt_seq
  import ckpt_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     attack_i,
  input  logic     full_i,
  input  logic     empty_i,
  input  logic     hit_i,
  input  logic     save_ack_i,
  input  logic     wb_ack_i,
  input  logic     rest_ack_i,
  input  logic     inval_ack_i,
  output ckpt_st_e state_o,
  output logic     rollback_o,
  output logic     flush_o,
  output logic     clear_o
);
  ckpt_st_e st_q, st_d;
  logic     flush_q;

  assign rollback_o = (st_q == ST_RUN) && attack_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_RUN: begin
        if (attack_i)           st_d = ST_REST;
        else if (full_i || hit_i) st_d = ST_SAVE;
      end
      ST_SAVE:  if (save_ack_i)  st_d = ST_WB;
      ST_WB:    if (wb_ack_i)    st_d = ST_DRAIN;
      ST_DRAIN: if (empty_i)     st_d = ST_RUN;
      ST_REST:  if (rest_ack_i)  st_d = ST_BYP;
      ST_BYP:   if (!attack_i)   st_d = ST_INVAL;
      ST_INVAL: if (inval_ack_i) st_d = ST_RUN;
      default:                   st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_RUN;
      flush_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      flush_q <= rollback_o;
    end
  end

  assign state_o = st_q;
  assign flush_o = flush_q;
  assign clear_o = flush_q;
endmodule

// File: rtl/ckpt_ctrl.sv
module ckpt_ctrl
  import ckpt_pkg::*;
#(
  parameter int INTVL_LONG  = 1000,
  parameter int INTVL_SHORT = 250,
  parameter int WBUF_DEPTH  = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic attack_i,
  input  logic wbuf_wr_i,
  input  logic wbuf_rd_i,
  output logic save_req_o,
  input  logic save_ack_i,
  output logic wb_req_o,
  input  logic wb_ack_i,
  output logic restore_req_o,
  input  logic restore_ack_i,
  output logic flush_o,
  output logic wbuf_clear_o,
  output logic wbuf_drain_o,
  output logic cpu_halt_o,
  output logic bypass_o,
  output logic llc_inval_req_o,
  input  logic llc_inval_ack_i
);
  localparam int OCC_W = $clog2(WBUF_DEPTH + 1);

  ckpt_st_e         state;
  logic             rollback, full, empty, hit, run;
  logic [OCC_W-1:0] occ;

  assign run = (state == ST_RUN);

  ckpt_occ #(.WBUF_DEPTH(WBUF_DEPTH)) u_occ (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wbuf_wr_i),
    .rd_i    (wbuf_rd_i),
    .gate_i  (wbuf_drain_o),
    .clear_i (rollback),
    .full_o  (full),
    .empty_o (empty),
    .occ_o   (occ)
  );

  ckpt_intvl #(.INTVL_LONG(INTVL_LONG), .INTVL_SHORT(INTVL_SHORT)) u_intvl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .mark_i (rollback),
    .hit_o  (hit)
  );

  ckpt_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .attack_i    (attack_i),
    .full_i      (full),
    .empty_i     (empty),
    .hit_i       (hit),
    .save_ack_i  (save_ack_i),
    .wb_ack_i    (wb_ack_i),
    .rest_ack_i  (restore_ack_i),
    .inval_ack_i (llc_inval_ack_i),
    .state_o     (state),
    .rollback_o  (rollback),
    .flush_o     (flush_o),
    .clear_o     (wbuf_clear_o)
  );

  assign save_req_o      = (state == ST_SAVE);
  assign wb_req_o        = (state == ST_WB);
  assign wbuf_drain_o    = (state == ST_DRAIN);
  assign restore_req_o   = (state == ST_REST);
  assign llc_inval_req_o = (state == ST_INVAL);
  assign bypass_o        = (state == ST_REST) || (state == ST_BYP);
  assign cpu_halt_o      = !run && (state != ST_BYP);
endmodule

// File: rtl/ckpt_ctrl_chk.sv
module ckpt_ctrl_chk #(
  parameter int WBUF_DEPTH = 8,
  localparam int OCC_W = $clog2(WBUF_DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             attack_i,
  input logic             save_req_i,
  input logic             save_ack_i,
  input logic             wb_req_i,
  input logic             restore_req_i,
  input logic             flush_i,
  input logic             drain_i,
  input logic             halt_i,
  input logic             bypass_i,
  input logic             inval_req_i,
  input logic [OCC_W-1:0] occ_i
);
  logic run;
  assign run = !halt_i && !bypass_i;

  // R3
  save_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (save_req_i && !save_ack_i) |=> save_req_i);
  // R3
  wb_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (save_req_i && save_ack_i) |=> (wb_req_i && !save_req_i));
  // R4
  drain_halted_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drain_i |-> halt_i);
  // R4
  drain_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drain_i && occ_i != '0) |=> drain_i);
  // R5
  full_force_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && !attack_i && occ_i == OCC_W'(WBUF_DEPTH)) |=> (save_req_i && halt_i));
  // R6
  halt_cover_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (save_req_i || restore_req_i || inval_req_i) |-> halt_i);
  // R7
  rollback_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && attack_i) |=> (restore_req_i && flush_i && bypass_i && occ_i == '0));
  // R7
  flush_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !flush_i);
  // R8
  no_ckpt_bypass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bypass_i |-> !save_req_i);
  // R9
  attack_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bypass_i && !halt_i && !attack_i) |=> (inval_req_i && !bypass_i));
endmodule

bind ckpt_ctrl ckpt_ctrl_chk #(.WBUF_DEPTH(WBUF_DEPTH)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .attack_i      (attack_i),
  .save_req_i    (save_req_o),
  .save_ack_i    (save_ack_i),
  .wb_req_i      (wb_req_o),
  .restore_req_i (restore_req_o),
  .flush_i       (flush_o),
  .drain_i       (wbuf_drain_o),
  .halt_i        (cpu_halt_o),
  .bypass_i      (bypass_o),
  .inval_req_i   (llc_inval_req_o),
  .occ_i         (occ)
);

// File: tb/ckpt_ctrl_tb.sv
module ckpt_ctrl_tb;
  localparam int DEPTH = 8;
  localparam int LONG  = 40;
  localparam int SHORT = 12;
  localparam int EV_SAVE  = 0;
  localparam int EV_REST  = 1;
  localparam int EV_INVAL = 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_ni = 1'b0;
  logic attack = 1'b0, wbuf_wr = 1'b0, wbuf_rd = 1'b0;
  logic save_ack = 1'b0, wb_ack = 1'b0, rest_ack = 1'b0, inval_ack = 1'b0;
  logic save_req, wb_req, restore_req, flush, wbuf_clear, drain, halt, bypass, inval_req;

  ckpt_ctrl #(.INTVL_LONG(LONG), .INTVL_SHORT(SHORT), .WBUF_DEPTH(DEPTH)) u_dut (
    .clk_i           (clk),
    .rst_ni          (rst_ni),
    .attack_i        (attack),
    .wbuf_wr_i       (wbuf_wr),
    .wbuf_rd_i       (wbuf_rd),
    .save_req_o      (save_req),
    .save_ack_i      (save_ack),
    .wb_req_o        (wb_req),
    .wb_ack_i        (wb_ack),
    .restore_req_o   (restore_req),
    .restore_ack_i   (rest_ack),
    .flush_o         (flush),
    .wbuf_clear_o    (wbuf_clear),
    .wbuf_drain_o    (drain),
    .cpu_halt_o      (halt),
    .bypass_o        (bypass),
    .llc_inval_req_o (inval_req),
    .llc_inval_ack_i (inval_ack)
  );

  int n_cmp = 0, n_bad = 0, n_seen = 0, bcnt = 0;

  typedef struct {int kind; int gap; string req;} exp_t;
  exp_t sb[$];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic expect_ev(input int kind, input int gap, input string req);
    exp_t e;
    e.kind = kind; e.gap = gap; e.req = req;
    sb.push_back(e);
  endtask

  task automatic observe(input int kind, input int gap);
    exp_t e;
    n_seen++;
    if (sb.size() == 0) begin
      chk(1'b0, "R8", "unexpected event kind", kind, -1);
    end else begin
      e = sb.pop_front();
      chk(e.kind == kind, e.req, "event kind", kind, e.kind);
      if (e.gap >= 0) chk(gap == e.gap, e.req, "run cycles before event", gap, e.gap);
    end
  endtask

  // buffer model and acknowledge stubs
  initial begin
    int cs = 0, cw = 0, cr = 0, ci = 0;
    forever begin
      @(posedge clk);
      if (wbuf_clear) bcnt = 0;
      else begin
        if (wbuf_wr && bcnt < DEPTH) bcnt++;
        if (wbuf_rd && bcnt > 0) bcnt--;
      end
      #1;
      wbuf_rd   = drain && bcnt > 0;
      save_ack  = save_req && cs == 2;     cs = save_req ? cs + 1 : 0;
      wb_ack    = wb_req && cw == 3;       cw = wb_req ? cw + 1 : 0;
      rest_ack  = restore_req && cr == 2;  cr = restore_req ? cr + 1 : 0;
      inval_ack = inval_req && ci == 4;    ci = inval_req ? ci + 1 : 0;
    end
  end

  // monitor
  initial begin
    int run_n = 0, p_bcnt = 0;
    logic p_save = 0, p_wb = 0, p_drain = 0, p_rest = 0, p_inval = 0, p_flush = 0, p_byp = 0;
    forever begin
      @(negedge clk);
      if (!rst_ni) begin
        run_n = 0;
        p_save = 0; p_wb = 0; p_drain = 0; p_rest = 0; p_inval = 0; p_flush = 0; p_byp = 0;
      end else begin
        if (save_req && !p_save) observe(EV_SAVE, run_n);
        if (restore_req && !p_rest) observe(EV_REST, run_n);
        if (inval_req && !p_inval) begin
          observe(EV_INVAL, run_n);
          chk(p_byp, "R9", "bypass before invalidate", int'(p_byp), 1);
        end
        if (wb_req && !p_wb) chk(p_save && !save_req, "R3", "write-back right after save", int'(p_save), 1);
        if (save_req && wb_req) chk(1'b0, "R3", "save and write-back overlap", 1, 0);
        if (drain && !p_drain) chk(p_wb && !wb_req, "R4", "drain right after write-back", int'(p_wb), 1);
        if (!drain && p_drain) chk(p_bcnt == 0, "R4", "occupancy when drain closes", p_bcnt, 0);
        if (save_req || wb_req || drain || restore_req || inval_req)
          chk(halt, "R6", "halt during maintenance", int'(halt), 1);
        else
          chk(!halt, "R6", "halt outside maintenance", int'(halt), 0);
        if (bypass) chk(!save_req, "R8", "save during bypass", int'(save_req), 0);
        if (flush) chk(!p_flush, "R7", "flush longer than one cycle", 1, 0);
        if (!halt && !bypass) run_n++; else run_n = 0;
        p_save = save_req; p_wb = wb_req; p_drain = drain; p_rest = restore_req;
        p_inval = inval_req; p_flush = flush; p_byp = bypass; p_bcnt = bcnt;
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", "run did not complete", 0, 1);
    finish_run();
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic push_n(input int n);
    wbuf_wr = 1'b1;
    repeat (n) @(posedge clk);
    #1;
    wbuf_wr = 1'b0;
  endtask

  task automatic wait_events(input int k);
    while (n_seen < k) @(negedge clk);
  endtask

  task automatic wait_run();
    do @(negedge clk); while (halt || bypass);
    @(posedge clk);
    #1;
  endtask

  initial begin
    step(3);
    @(negedge clk);
    chk({save_req, wb_req, restore_req, flush, wbuf_clear, drain, halt, bypass, inval_req} == '0,
        "R1", "outputs in reset",
        int'({save_req, wb_req, restore_req, flush, wbuf_clear, drain, halt, bypass, inval_req}), 0);
    expect_ev(EV_SAVE, LONG, "R2");
    @(posedge clk); #1;
    rst_ni = 1'b1;
    wait_events(1);
    wait_run();

    // periodic with writes pending; R4 drain empties them
    expect_ev(EV_SAVE, LONG, "R2");
    step(10);
    push_n(4);
    wait_events(2);
    wait_run();

    // R5 forced checkpoint on full buffer
    expect_ev(EV_SAVE, -1, "R5");
    step(3);
    push_n(DEPTH);
    @(negedge clk);
    chk(!halt && !save_req, "R5", "no checkpoint before full seen", int'(save_req), 0);
    @(negedge clk);
    chk(halt && save_req, "R5", "checkpoint after full", int'(save_req), 1);
    wait_events(3);
    wait_run();

    // R11 interval restarts after forced checkpoint
    expect_ev(EV_SAVE, LONG, "R11");
    wait_events(4);
    wait_run();

    // R7 sudden attack with five writes pending
    step(5);
    push_n(5);
    expect_ev(EV_REST, -1, "R7");
    attack = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(restore_req && flush && wbuf_clear && bypass && halt, "R7", "rollback strobes",
        int'({restore_req, flush, wbuf_clear, bypass, halt}), 31);
    @(negedge clk);
    chk(!flush, "R7", "flush dropped", int'(flush), 0);
    step(3 * LONG);
    chk(n_seen == 5 && bypass && !halt, "R8", "events during attack", n_seen, 5);

    // R9 attack ends
    expect_ev(EV_INVAL, -1, "R9");
    attack = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(inval_req && !bypass && halt, "R9", "invalidate with bypass low",
        int'({inval_req, bypass, halt}), 5);
    wait_events(6);
    wait_run();

    // R10 shortened interval; R7 old occupancy discarded
    expect_ev(EV_SAVE, SHORT, "R10");
    expect_ev(EV_SAVE, SHORT, "R10");
    push_n(3);
    @(negedge clk);
    chk(!halt, "R7", "no forced checkpoint after discard", int'(halt), 0);
    @(negedge clk);
    chk(!halt, "R7", "no forced checkpoint after discard", int'(halt), 0);
    wait_events(8);
    wait_run();
    step(2);
    chk(sb.size() == 0, "R10", "expected events left", sb.size(), 0);
    finish_run();
  end
endmodule